// File: doc/BRIEF.md
# Idle-Mode DMA Channel with Terminal Count

This block is a single DMA channel that moves one data unit for each activation request it accepts. Software loads a memory address, a fixed I/O-side address, a 16-bit transfer count and a control word through a small register port. The channel then watches one request line, picked out of sixteen by a select field. For each accepted request it runs one bus read followed by one bus write on a single-cycle master port. The control word sets the direction (memory to I/O or I/O to memory), the unit size (byte or 16-bit word) and whether the memory address goes up or down.

After each write the count drops by one. When it reaches zero the channel clears its own enable bit, stops taking requests and, if allowed, raises an interrupt that holds until software deals with it. A loaded count of zero stands for 65,536 transfers. Enabling is guarded: software must first read the control register while the channel is off, and only then does a write of the enable bit take effect. A word transfer that would use an odd address is refused. The channel stops and sets an error flag.

The sequencer has three states. In IDLE it waits for a request. The transition IDLE->READ happens on an accepted request. IDLE stays IDLE, with a fault, when the addresses are misaligned. READ->WRITE always follows. WRITE->IDLE always follows and counts the transfer.

Top module: `dma_idle_chan`

## Requirements
- R1: After reset the memory address, I/O address, count and control registers read zero, and the bus strobes, interrupt and acknowledge lines are low.
- R2: A write of 1 to the enable bit (control bit 0) takes effect only when the channel is off and the previous control-register access was a read strobe (`cfg_re`) made while enable was 0. Any control write uses up that permission.
- R3: An accepted request produces exactly one read cycle and, in the very next cycle, one write cycle. With direction bit 3 = 0 the read goes to the memory address and the write to the I/O address. With bit 3 = 1 it is the other way round. The written data is the data read, with only the low byte kept in byte mode.
- R4: After each write the memory address moves by the unit size (1 for bytes, 2 for words with size bit 2 = 1). It moves up when bit 4 = 0 and down when bit 4 = 1. The I/O address never changes.
- R5: The count (register select 2) falls by one per transfer. A count loaded as 0 reads 0xFFFF after one transfer, and the channel remains enabled.
- R6: When the count reaches zero the enable bit clears by hardware, and no further bus cycle starts while a request is still held.
- R7: If interrupt-enable bit 1 is set when the count reaches zero, `irq` rises and stays high until a control write with bit 0 = 1 or bit 1 = 0. With bit 1 = 0 no interrupt is raised.
- R8: With auto-acknowledge bit 5 set, the accepted request gets a one-cycle pulse on its own `req_ack` line in the accepting cycle. With bit 5 clear, `req_ack` stays zero.
- R9: Only the request line selected by control bits 9:6 can start a transfer.
- R10: In word mode, an odd memory or I/O address at the moment a request is accepted starts no bus cycle. It clears enable and sets error bit 10, and the next control write clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe, used to arm enabling |
| cfg_sel | input | 2 | Register select: 0 memory address, 1 I/O address, 2 count, 3 control |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Selected register contents |
| req_in | input | NSRC | Activation request lines |
| req_ack | output | NSRC | Automatic acknowledge pulses |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_word | output | 1 | Transfer unit is a 16-bit word |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid in the read cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The bench runs transfer lists that mix direction, unit size and address direction, and checks the address pattern on the bus and the final register values. A wrong step size or a swapped direction would show up as a bad last address or bad data. Loading a count of zero checks that one transfer leaves 0xFFFF with the channel still running; a design that treated zero as "done" would stop at once. The bench also covers:
- an enable write made without the arming read, which a careless design would accept;
- a request held after terminal count, which a design that did not clear its enable would keep serving;
- odd word addresses, which a design without the alignment check would put on the bus.

// File: rtl/dma_idle_pkg.sv
package dma_idle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    localparam logic [1:0] SEL_MEM = 2'd0;
    localparam logic [1:0] SEL_IO  = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    // control flag bits 5:0 (en lands at bit 0)
    typedef struct packed {
        logic autoack;
        logic down;
        logic io_to_mem;
        logic word;
        logic ie;
        logic en;
    } ctl_flags_t;

    localparam int FLAG_W = 6;

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_idle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic req_hit,
    input  logic addr_bad,
    output logic accept,
    output logic fault,
    output logic rd_phase,
    output logic wr_phase
);

    dma_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (chan_en && req_hit && !addr_bad) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        fault    = 1'b0;
        rd_phase = 1'b0;
        wr_phase = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = chan_en && req_hit && !addr_bad;
                fault  = chan_en && req_hit && addr_bad;
            end
            ST_READ:  rd_phase = 1'b1;
            ST_WRITE: wr_phase = 1'b1;
            default: ;
        endcase
    end

    // R3: one read then one write per accepted request
    a_r3_accept_reads: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rd_phase);
    a_r3_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase |=> wr_phase);
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> !rd_phase && !wr_phase);

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - ONE;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == ONE);

    // R5: each completed transfer removes exactly one from the count
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> cnt_q == $past(cnt_q) - ONE);

endmodule

// File: rtl/dma_mem_addr.sv
module dma_mem_addr #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          word,
    input  logic          down,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] delta;

    assign delta = word ? AW'(2) : AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= load_val;
        else if (step) addr_q <= down ? addr_q - delta : addr_q + delta;
    end

    assign addr = addr_q;

    // R4: address moves by the unit size in the programmed direction
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !down && !word) |=> addr_q == $past(addr_q) + AW'(1));
    a_r4_step_down_word: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && down && word) |=> addr_q == $past(addr_q) - AW'(2));

endmodule

// File: rtl/dma_idle_chan.sv
module dma_idle_chan
    import dma_idle_pkg::*;
#(
    parameter int AW   = 24,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_re,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    output logic [AW-1:0]   cfg_rdata,
    input  logic [NSRC-1:0] req_in,
    output logic [NSRC-1:0] req_ack,
    output logic            bus_rd,
    output logic            bus_wr,
    output logic            bus_word,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic            irq
);

    localparam int SW      = $clog2(NSRC);
    localparam int CTL_W   = FLAG_W + SW + 1;
    localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);

    ctl_flags_t    flags_q, ctl_new;
    logic [SW-1:0] src_q;
    logic [AW-1:0] io_q;
    logic [DW-1:0] data_q;
    logic          arm_q, irq_q, err_q;

    logic [AW-1:0] mar;
    logic [CW-1:0] cnt;
    logic          cnt_last;
    logic          accept, fault, rd_phase, wr_phase;
    logic          req_hit, addr_bad, wr_ctl, terminal;

    assign wr_ctl   = cfg_we && (cfg_sel == SEL_CTL);
    assign req_hit  = req_in[src_q];
    assign addr_bad = flags_q.word && (mar[0] || io_q[0]);
    assign terminal = wr_phase && cnt_last;

    always_comb begin
        ctl_new    = ctl_flags_t'(cfg_wdata[FLAG_W-1:0]);
        ctl_new.en = cfg_wdata[0] && (flags_q.en || arm_q);
    end

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (flags_q.en),
        .req_hit  (req_hit),
        .addr_bad (addr_bad),
        .accept   (accept),
        .fault    (fault),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase)
    );

    dma_xfer_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_we && (cfg_sel == SEL_CNT)),
        .load_val (cfg_wdata[CW-1:0]),
        .dec      (wr_phase),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    dma_mem_addr #(.AW(AW)) u_mar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_we && (cfg_sel == SEL_MEM)),
        .load_val (cfg_wdata),
        .step     (wr_phase),
        .word     (flags_q.word),
        .down     (flags_q.down),
        .addr     (mar)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            src_q   <= '0;
            io_q    <= '0;
            data_q  <= '0;
            arm_q   <= 1'b0;
            irq_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (wr_ctl) begin
                flags_q <= ctl_new;
                src_q   <= cfg_wdata[FLAG_W +: SW];
            end
            if (terminal || fault) flags_q.en <= 1'b0;

            if (wr_ctl)
                arm_q <= 1'b0;
            else if (cfg_re && (cfg_sel == SEL_CTL) && !flags_q.en)
                arm_q <= 1'b1;

            if (terminal && flags_q.ie)
                irq_q <= 1'b1;
            else if (wr_ctl && (cfg_wdata[0] || !cfg_wdata[1]))
                irq_q <= 1'b0;

            if (fault)       err_q <= 1'b1;
            else if (wr_ctl) err_q <= 1'b0;

            if (cfg_we && (cfg_sel == SEL_IO)) io_q <= cfg_wdata;

            if (rd_phase)
                data_q <= flags_q.word ? bus_rdata : (bus_rdata & BYTE_MASK);
        end
    end

    always_comb begin
        unique case (cfg_sel)
            SEL_MEM: cfg_rdata = mar;
            SEL_IO:  cfg_rdata = io_q;
            SEL_CNT: cfg_rdata = AW'(cnt);
            default: cfg_rdata = AW'({err_q, src_q, flags_q});
        endcase
    end

    assign bus_rd    = rd_phase;
    assign bus_wr    = wr_phase;
    assign bus_word  = flags_q.word;
    assign bus_wdata = data_q;
    assign bus_addr  = (rd_phase ^ flags_q.io_to_mem) ? mar : io_q;
    assign req_ack   = (accept && flags_q.autoack) ? (NSRC'(1) << src_q) : '0;
    assign irq       = irq_q;

    // R8: at most one acknowledge line pulses
    a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ack));
    // R6: a disabled, quiet channel starts no read
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_q.en && !bus_rd && !bus_wr) |=> !bus_rd);
    // R7: the interrupt only rises right after the last transfer
    a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cnt_last && wr_phase));
    // R10: a refused request puts nothing on the bus
    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !bus_rd && !bus_wr);

    initial begin
        assert (AW >= CTL_W && AW >= CW && DW >= 8)
            else $error("dma_idle_chan: widths too narrow");
    end

endmodule

// File: tb/test_dma_idle_chan.sv
`timescale 1ns/1ps
module test_dma_idle_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_re = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic [15:0] req_in = '0;
    logic [15:0] req_ack;
    logic        bus_rd, bus_wr, bus_word, irq;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    int total = 0;
    int bad = 0;
    int nrd = 0, nwr = 0, nack = 0;
    logic [23:0] last_ra, last_wa;
    logic [15:0] last_wd;

    always #2.5 clk = ~clk;

    assign bus_rdata = {bus_addr[7:0] ^ 8'h3C, bus_addr[7:0]};

    dma_idle_chan i_dma_idle_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_in(req_in), .req_ack(req_ack), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_rd) begin nrd++; last_ra = bus_addr; end
            if (bus_wr) begin nwr++; last_wa = bus_addr; last_wd = bus_wdata; end
            if (req_ack != '0) nack++;
        end
    end

    typedef struct packed {
        logic        dir;
        logic        word;
        logic        down;
        logic        ie;
        logic [23:0] mar;
        logic [23:0] io;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 24'h000100, 24'h000040, 16'd3},
        '{1'b1, 1'b1, 1'b1, 1'b1, 24'h000200, 24'h000082, 16'd2},
        '{1'b0, 1'b1, 1'b0, 1'b0, 24'h000010, 24'h000020, 16'd4},
        '{1'b1, 1'b0, 1'b1, 1'b1, 24'h000005, 24'h000033, 16'd1}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] s, input logic [23:0] d);
        cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic arm();
        cfg_sel = 2'd3; cfg_re = 1'b1;
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [23:0] v);
        cfg_sel = s;
        #0.5;
        v = cfg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] v, ctl, step, lastm, fin, src, dst;
        logic [15:0] wd;
        int r0, w0, a0;

        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1 strobes", {bus_rd, bus_wr, irq}, 0);
        chk("R1 ack", req_ack, 0);
        peek(3, v); chk("R1 ctl", v, 0);
        peek(2, v); chk("R1 cnt", v, 0);
        peek(0, v); chk("R1 mar", v, 0);
        peek(1, v); chk("R1 io", v, 0);

        // R2: guarded enable
        wreg(3, 24'h1);
        peek(3, v); chk("R2 enable without read", v[0], 0);
        arm(); wreg(3, 24'h1);
        peek(3, v); chk("R2 enable after read", v[0], 1);
        wreg(3, 24'h0); wreg(3, 24'h1);
        peek(3, v); chk("R2 second write needs new read", v[0], 0);

        // table of transfer runs: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 4; i++) begin
            wreg(0, VECS[i].mar);
            wreg(1, VECS[i].io);
            wreg(2, 24'(VECS[i].cnt));
            ctl = (24'd2 << 6) | (24'(VECS[i].down) << 4) | (24'(VECS[i].dir) << 3)
                | (24'(VECS[i].word) << 2) | (24'(VECS[i].ie) << 1);
            wreg(3, ctl);
            arm();
            wreg(3, ctl | 24'h1);
            r0 = nrd; w0 = nwr; a0 = nack;
            req_in[2] = 1'b1;
            for (int k = 0; k < 200; k++) begin
                peek(3, v);
                if (!v[0]) break;
                cyc(1);
            end
            cyc(5);
            req_in[2] = 1'b0;
            step  = VECS[i].word ? 24'd2 : 24'd1;
            lastm = VECS[i].down ? VECS[i].mar - step * (VECS[i].cnt - 1)
                                 : VECS[i].mar + step * (VECS[i].cnt - 1);
            fin   = VECS[i].down ? lastm - step : lastm + step;
            src   = VECS[i].dir ? VECS[i].io : lastm;
            dst   = VECS[i].dir ? lastm : VECS[i].io;
            wd    = VECS[i].word ? {src[7:0] ^ 8'h3C, src[7:0]} : {8'h00, src[7:0]};
            chk("R6 reads stop at count", nrd - r0, VECS[i].cnt);
            chk("R5 one write per unit", nwr - w0, VECS[i].cnt);
            chk("R3 read address", last_ra, src);
            chk("R3 write address", last_wa, dst);
            chk("R3 write data", last_wd, wd);
            peek(0, v); chk("R4 final memory address", v, fin);
            peek(1, v); chk("R4 io address fixed", v, VECS[i].io);
            peek(2, v); chk("R5 count at zero", v, 0);
            peek(3, v); chk("R6 enable cleared", v[0], 0);
            chk("R7 irq follows enable bit", irq, VECS[i].ie);
            chk("R8 no ack without auto bit", nack - a0, 0);
            wreg(3, 24'h0);
            chk("R7 irq cleared by write", irq, 0);
        end

        // R7: irq cleared by writing enable again
        wreg(0, 24'h400); wreg(2, 24'd1);
        wreg(3, (24'd2 << 6) | 24'h2); arm(); wreg(3, (24'd2 << 6) | 24'h3);
        req_in[2] = 1'b1; cyc(5); req_in[2] = 1'b0;
        chk("R7 irq raised", irq, 1);
        wreg(3, (24'd2 << 6) | 24'h3);
        chk("R7 irq cleared by enable write", irq, 0);

        // R9, R8, R5: source 5, auto-ack, count zero
        wreg(3, 24'h0);
        wreg(0, 24'h300); wreg(2, 24'd0);
        ctl = (24'd5 << 6) | (24'd1 << 5);
        wreg(3, ctl); arm(); wreg(3, ctl | 24'h1);
        r0 = nrd; a0 = nack;
        req_in[3] = 1'b1; cyc(4); req_in[3] = 1'b0;
        chk("R9 unselected line ignored", nrd - r0, 0);
        req_in[5] = 1'b1;
        #0.5;
        chk("R8 ack on selected line", req_ack, 16'h0020);
        @(negedge clk);
        req_in[5] = 1'b0;
        cyc(4);
        chk("R8 single ack pulse", nack - a0, 1);
        chk("R3 one read per request", nrd - r0, 1);
        peek(2, v); chk("R5 zero wraps to FFFF", v, 24'h00FFFF);
        peek(3, v); chk("R5 still enabled", v[0], 1);
        wreg(3, 24'h0);

        // R10: odd address in word mode
        wreg(0, 24'h101); wreg(1, 24'h40); wreg(2, 24'd5);
        ctl = (24'd2 << 6) | (24'd1 << 2);
        wreg(3, ctl); arm(); wreg(3, ctl | 24'h1);
        r0 = nrd;
        req_in[2] = 1'b1; cyc(4); req_in[2] = 1'b0;
        chk("R10 no bus cycle", nrd - r0, 0);
        peek(3, v); chk("R10 enable cleared", v[0], 0);
        chk("R10 error set", v[10], 1);
        peek(2, v); chk("R10 count untouched", v, 5);
        wreg(3, 24'h0);
        peek(3, v); chk("R10 error cleared", v[10], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule